// File: doc/BRIEF.md
# Display Command Stream Register Decoder

This block sits between a byte-wide command stream and the video timing register file of a display controller. Bytes arrive one per cycle under a valid/ready handshake. The block splits them into command packets that start with a fixed prefix byte. It turns register-set packets into updates of a small set of video control outputs: blanking mode, colour depth and the base pointers of the two framebuffer planes. It parses pixel-copy packets and reports each one with a single-cycle strobe and the decoded fields.

A lock register lets software stage a group of register changes. While the lock is held, writes collect in a shadow copy and the outputs do not move. Writing the unlock value moves every staged value to the outputs on the same clock edge. The block flags malformed framing with a sticky error bit and then waits for the next prefix byte. A packet that stalls for too long is dropped, so a lost byte cannot leave the parser stuck in the middle of a packet.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset, `blankMode` is 0x07, `colorDepth` is 0, both base pointers are 0, `errFlag` is 0 and `copyStrobe` is 0. `inReady` rises on the first clock edge after reset is released.
- R2: A register-set packet is the bytes 0xAF, 0x20, index, value. With the lock released, its effect shows on the outputs in the cycle after the clock edge that accepts the value byte.
- R3: The write (index 0xFF, value 0x00) engages the lock. While the lock is held, register writes leave every output unchanged. The write (index 0xFF, value 0xFF) moves all staged values to the outputs together, in the cycle after its value byte is accepted.
- R4: Index 0x1F sets `blankMode`. Only the codes 0x00 (syncs on), 0x01 (syncs off, panel powered), 0x05 (standby) and 0x07 (power-down) are taken. Any other value leaves the mode as it was.
- R5: Index 0x00 sets `colorDepth` from bit 0 of the value: 0 selects 16 bpp and 1 selects 24 bpp.
- R6: For `base16`, index 0x20 sets bits 23:16, index 0x21 sets bits 15:8 and index 0x22 sets bits 7:0. For `base8`, indices 0x26, 0x27 and 0x28 set the same byte lanes in the same order.
- R7: A copy packet is 0xAF, 0x6A, a 3-byte source address (most significant byte first), a 1-byte pixel count and a 3-byte destination address (most significant byte first), nine bytes in all. `copyStrobe` is high for exactly the one cycle after the last byte is accepted, with `copySrc`, `copyCount` and `copyDst` holding the fields.
- R8: A byte other than 0xAF in the prefix position, or an opcode other than 0x20 or 0x6A, sets `errFlag`, which stays set until reset. The decoder then ignores bytes until it sees 0xAF, and treats that byte as the prefix of a new packet.
- R9: If a packet has started and no byte is accepted for IDLE_LIMIT consecutive cycles (default 16), the packet is dropped and the next byte is taken as a prefix. Shorter gaps do not disturb a packet.
- R10: A write to any index not named in R3 to R6, or a write to index 0xFF with a value other than 0x00 or 0xFF, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inByte | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Decoder accepts a byte |
| blankMode | output | 8 | Active blanking code |
| colorDepth | output | 1 | 0 selects 16 bpp, 1 selects 24 bpp |
| base16 | output | 24 | Base pointer of the 16 bpp plane |
| base8 | output | 24 | Base pointer of the 8 bpp plane |
| copyStrobe | output | 1 | One-cycle pulse when a copy packet completes |
| copySrc | output | 24 | Source address of the last copy packet |
| copyCount | output | 8 | Pixel count of the last copy packet |
| copyDst | output | 24 | Destination address of the last copy packet |
| errFlag | output | 1 | Sticky framing error |

## Verification
Every result is registered once, at the clock edge that accepts the packet's final byte. A register write, an unlock commit, a copy strobe and an error flag therefore all show up one cycle after that byte. The copy strobe is low again one cycle later. The bench drives each byte in the half cycle before an edge and samples at the falling edge that follows. It checks outputs right after a packet's last byte, and it checks the strobe again one cycle later. Idle-timeout cases wait well beyond IDLE_LIMIT, and in-limit gaps stay well below it, so neither case rests on an exact cycle boundary.

// File: rtl/vidcmd_pkg.sv
`timescale 1ns/1ps
package vidcmd_pkg;
  localparam logic [7:0] PREFIX   = 8'hAF;
  localparam logic [7:0] OP_REG   = 8'h20;
  localparam logic [7:0] OP_COPY  = 8'h6A;
  localparam logic [7:0] IDX_LOCK = 8'hFF;
  localparam int         COPY_LEN = 7;

  typedef enum logic [2:0] {
    ST_PFX, ST_OPC, ST_IDX, ST_VAL, ST_CPY, ST_SKIP
  } parseState_t;

  typedef struct packed {
    logic        regWr;
    logic [7:0]  regIdx;
    logic [7:0]  regVal;
    logic        cpyWr;
    logic [2:0]  cpyPos;
    logic [7:0]  cpyByte;
    logic        cpyDone;
  } ctlStrb_t;

  typedef struct packed {
    logic [7:0]  blank;
    logic        depth;
    logic [23:0] b16;
    logic [23:0] b8;
  } vidRegs_t;

  function automatic vidRegs_t applyWrite(vidRegs_t cur, logic [7:0] idx, logic [7:0] val);
    vidRegs_t nxt = cur;
    case (idx)
      8'h00: nxt.depth = val[0];
      8'h1F: if (val == 8'h00 || val == 8'h01 || val == 8'h05 || val == 8'h07) nxt.blank = val;
      8'h20: nxt.b16[23:16] = val;
      8'h21: nxt.b16[15:8]  = val;
      8'h22: nxt.b16[7:0]   = val;
      8'h26: nxt.b8[23:16]  = val;
      8'h27: nxt.b8[15:8]   = val;
      8'h28: nxt.b8[7:0]    = val;
      default: ;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/vidcmd_ctrl.sv
`timescale 1ns/1ps
module vidcmd_ctrl
  import vidcmd_pkg::*;
#(
  parameter int IDLE_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  output logic       inReady,
  output logic       errFlag,
  output ctlStrb_t   strb
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  parseState_t state;
  logic [7:0]  idxQ;
  logic [2:0]  cpyPos;
  logic [CW-1:0] idleCnt;
  logic        readyQ;
  logic        take;
  logic        midPkt;

  assign inReady = readyQ;
  assign take    = inValid && readyQ;
  assign midPkt  = (state == ST_OPC) || (state == ST_IDX) || (state == ST_VAL) || (state == ST_CPY);

  always_comb begin
    strb         = '0;
    strb.regIdx  = idxQ;
    strb.regVal  = inByte;
    strb.cpyPos  = cpyPos;
    strb.cpyByte = inByte;
    if (take && state == ST_VAL) strb.regWr = 1'b1;
    if (take && state == ST_CPY) begin
      strb.cpyWr   = 1'b1;
      strb.cpyDone = (cpyPos == 3'(COPY_LEN - 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PFX;
      idxQ    <= '0;
      cpyPos  <= '0;
      idleCnt <= '0;
      readyQ  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (take) begin
        idleCnt <= '0;
        case (state)
          ST_PFX: if (inByte == PREFIX) state <= ST_OPC;
                  else begin errFlag <= 1'b1; state <= ST_SKIP; end
          ST_OPC: if (inByte == OP_REG) state <= ST_IDX;
                  else if (inByte == OP_COPY) begin state <= ST_CPY; cpyPos <= '0; end
                  else begin errFlag <= 1'b1; state <= ST_SKIP; end
          ST_IDX: begin idxQ <= inByte; state <= ST_VAL; end
          ST_VAL: state <= ST_PFX;
          ST_CPY: begin
            cpyPos <= cpyPos + 3'd1;
            if (cpyPos == 3'(COPY_LEN - 1)) state <= ST_PFX;
          end
          ST_SKIP: if (inByte == PREFIX) state <= ST_OPC;
          default: state <= ST_PFX;
        endcase
      end else if (midPkt) begin
        if (idleCnt == CW'(IDLE_LIMIT - 1)) begin
          state   <= ST_PFX;
          idleCnt <= '0;
        end else begin
          idleCnt <= idleCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vidcmd_dpath.sv
`timescale 1ns/1ps
module vidcmd_dpath
  import vidcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrb_t    strb,
  output vidRegs_t    active,
  output logic        vidLocked,
  output logic        copyStrobe,
  output logic [23:0] copySrc,
  output logic [7:0]  copyCount,
  output logic [23:0] copyDst
);
  vidRegs_t shadow, staged;
  vidRegs_t rstVal;

  assign rstVal = '{blank: 8'h07, depth: 1'b0, b16: 24'd0, b8: 24'd0};
  assign staged = applyWrite(shadow, strb.regIdx, strb.regVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow    <= rstVal;
      active    <= rstVal;
      vidLocked <= 1'b0;
    end else if (strb.regWr) begin
      if (strb.regIdx == IDX_LOCK) begin
        if (strb.regVal == 8'h00) vidLocked <= 1'b1;
        else if (strb.regVal == 8'hFF) begin
          vidLocked <= 1'b0;
          active    <= shadow;
        end
      end else begin
        shadow <= staged;
        if (!vidLocked) active <= staged;
      end
    end
  end

  logic [7:0] cpyBytes [COPY_LEN];

  for (genvar g = 0; g < COPY_LEN; g++) begin : g_cpy
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpyBytes[g] <= '0;
      else if (strb.cpyWr && strb.cpyPos == 3'(g)) cpyBytes[g] <= strb.cpyByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) copyStrobe <= 1'b0;
    else       copyStrobe <= strb.cpyDone;
  end

  assign copySrc   = {cpyBytes[0], cpyBytes[1], cpyBytes[2]};
  assign copyCount = cpyBytes[3];
  assign copyDst   = {cpyBytes[4], cpyBytes[5], cpyBytes[6]};
endmodule

// File: rtl/vidcmd_decoder.sv
`timescale 1ns/1ps
module vidcmd_decoder
  import vidcmd_pkg::*;
#(
  parameter int IDLE_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inByte,
  input  logic        inValid,
  output logic        inReady,
  output logic [7:0]  blankMode,
  output logic        colorDepth,
  output logic [23:0] base16,
  output logic [23:0] base8,
  output logic        copyStrobe,
  output logic [23:0] copySrc,
  output logic [7:0]  copyCount,
  output logic [23:0] copyDst,
  output logic        errFlag
);
  ctlStrb_t strb;
  vidRegs_t active;
  logic     vidLocked;

  vidcmd_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inReady(inReady), .errFlag(errFlag), .strb(strb)
  );

  vidcmd_dpath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .active(active), .vidLocked(vidLocked),
    .copyStrobe(copyStrobe), .copySrc(copySrc), .copyCount(copyCount), .copyDst(copyDst)
  );

  assign blankMode  = active.blank;
  assign colorDepth = active.depth;
  assign base16     = active.b16;
  assign base8      = active.b8;
endmodule

// File: rtl/vidcmd_chk.sv
`timescale 1ns/1ps
module vidcmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        vidLocked,
  input logic [7:0]  blankMode,
  input logic        colorDepth,
  input logic [23:0] base16,
  input logic [23:0] base8,
  input logic        copyStrobe,
  input logic        errFlag
);
  AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    copyStrobe |=> !copyStrobe); // R7

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (vidLocked && $past(vidLocked)) |-> ($stable(blankMode) && $stable(colorDepth)
      && $stable(base16) && $stable(base8))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8

  AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (blankMode == 8'h00) || (blankMode == 8'h01) || (blankMode == 8'h05)
      || (blankMode == 8'h07)); // R4
endmodule

bind vidcmd_decoder vidcmd_chk u_chk (
  .clk(clk), .rstN(rstN), .vidLocked(vidLocked), .blankMode(blankMode),
  .colorDepth(colorDepth), .base16(base16), .base8(base8),
  .copyStrobe(copyStrobe), .errFlag(errFlag)
);

// File: tb/sim_vidcmd_decoder.sv
`timescale 1ns/1ps
module sim_vidcmd_decoder;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic inValid = 1'b0;
  logic inReady, colorDepth, copyStrobe, errFlag;
  logic [7:0] blankMode, copyCount;
  logic [23:0] base16, base8, copySrc, copyDst;

  always #2 clk = ~clk;

  vidcmd_decoder #(.IDLE_LIMIT(16)) u0 (.*);

  int nChecks = 0, nFails = 0;
  // bench model: staged and visible copies
  logic [7:0] sBlank, aBlank; logic sDepth, aDepth;
  logic [23:0] sB16, aB16, sB8, aB8; logic mLock;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b, int gap);
    repeat (gap) @(negedge clk);
    inValid = 1'b1; inByte = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic modelWrite(logic [7:0] idx, logic [7:0] val);
    if (idx == 8'hFF) begin
      if (val == 8'h00) mLock = 1'b1;
      if (val == 8'hFF) begin
        mLock = 1'b0; aBlank = sBlank; aDepth = sDepth; aB16 = sB16; aB8 = sB8;
      end
      return;
    end
    if (idx == 8'h00) sDepth = val[0];
    if (idx == 8'h1F && (val == 8'h00 || val == 8'h01 || val == 8'h05 || val == 8'h07)) sBlank = val;
    if (idx == 8'h20) sB16[23:16] = val;
    if (idx == 8'h21) sB16[15:8] = val;
    if (idx == 8'h22) sB16[7:0] = val;
    if (idx == 8'h26) sB8[23:16] = val;
    if (idx == 8'h27) sB8[15:8] = val;
    if (idx == 8'h28) sB8[7:0] = val;
    if (!mLock) begin aBlank = sBlank; aDepth = sDepth; aB16 = sB16; aB8 = sB8; end
  endtask

  task automatic putReg(logic [7:0] idx, logic [7:0] val, int gap);
    sendByte(8'hAF, gap); sendByte(8'h20, gap); sendByte(idx, gap); sendByte(val, gap);
    modelWrite(idx, val);
  endtask

  task automatic checkAll(string req);
    chk(req, 32'(blankMode), 32'(aBlank));
    chk(req, 32'(colorDepth), 32'(aDepth));
    chk(req, 32'(base16), 32'(aB16));
    chk(req, 32'(base8), 32'(aB8));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] idxSet [8];
    idxSet = '{8'h00, 8'h1F, 8'h20, 8'h21, 8'h22, 8'h26, 8'h27, 8'h28};
    void'($urandom(32'd4242));
    sBlank = 8'h07; aBlank = 8'h07; sDepth = 0; aDepth = 0;
    sB16 = 0; aB16 = 0; sB8 = 0; aB8 = 0; mLock = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1");
    chk("R1", 32'(errFlag), 0); chk("R1", 32'(copyStrobe), 0); chk("R1", 32'(inReady), 1);

    // R2/R4/R5/R6 directed
    putReg(8'h1F, 8'h00, 0); checkAll("R2");
    putReg(8'h1F, 8'h05, 0); checkAll("R4");
    putReg(8'h1F, 8'h03, 0); chk("R4 illegal code", 32'(blankMode), 32'h05);
    putReg(8'h00, 8'h01, 0); chk("R5", 32'(colorDepth), 1);
    putReg(8'h20, 8'h12, 0); putReg(8'h21, 8'h34, 0); putReg(8'h22, 8'h56, 0);
    chk("R6 base16", 32'(base16), 32'h123456);
    putReg(8'h26, 8'hAB, 0); putReg(8'h27, 8'hCD, 0); putReg(8'h28, 8'hEF, 1);
    chk("R6 base8", 32'(base8), 32'hABCDEF);

    // R10 stray writes
    putReg(8'h40, 8'h99, 0); putReg(8'hFF, 8'h55, 0); putReg(8'h23, 8'h77, 0);
    checkAll("R10");

    // R3 lock window
    putReg(8'hFF, 8'h00, 0);
    putReg(8'h20, 8'h01, 0); putReg(8'h1F, 8'h01, 0); putReg(8'h00, 8'h00, 0);
    chk("R3 held base16", 32'(base16), 32'h123456);
    chk("R3 held blank", 32'(blankMode), 32'h05);
    putReg(8'hFF, 8'hFF, 0);
    chk("R3 commit base16", 32'(base16), 32'h013456);
    chk("R3 commit blank", 32'(blankMode), 32'h01);
    chk("R3 commit depth", 32'(colorDepth), 0);

    // R7 copy packet
    begin
      logic [7:0] cp [7];
      cp = '{8'h0A, 8'h0B, 8'h0C, 8'h20, 8'hD1, 8'hD2, 8'hD3};
      sendByte(8'hAF, 0); sendByte(8'h6A, 0);
      foreach (cp[i]) begin
        if (i == 6) chk("R7 no early strobe", 32'(copyStrobe), 0);
        sendByte(cp[i], i % 2);
      end
      chk("R7 strobe", 32'(copyStrobe), 1);
      chk("R7 src", 32'(copySrc), 32'h0A0B0C);
      chk("R7 count", 32'(copyCount), 32'h20);
      chk("R7 dst", 32'(copyDst), 32'hD1D2D3);
      @(negedge clk);
      chk("R7 one cycle", 32'(copyStrobe), 0);
    end

    // R9 short gap tolerated, long gap drops packet
    sendByte(8'hAF, 0); sendByte(8'h20, 0); sendByte(8'h1F, 10); sendByte(8'h07, 10);
    modelWrite(8'h1F, 8'h07); checkAll("R9 short gap");
    sendByte(8'hAF, 0); sendByte(8'h20, 0);
    repeat (24) @(negedge clk);
    putReg(8'h1F, 8'h00, 0);
    chk("R9 dropped", 32'(blankMode), 32'h00);
    chk("R9 no error", 32'(errFlag), 0);

    // random register traffic with lock
    for (int n = 0; n < 80; n++) begin
      int r = int'($urandom % 10);
      logic [7:0] v = 8'($urandom);
      int gap = int'($urandom % 3);
      if (r == 0) putReg(8'hFF, 8'h00, gap);
      else if (r == 1) putReg(8'hFF, 8'hFF, gap);
      else if (r == 2) putReg(8'h30 + 8'($urandom % 16), v, gap);
      else begin
        logic [7:0] ix = idxSet[$urandom % 8];
        if (ix == 8'h1F && v[0]) v = {5'd0, 3'($urandom % 8)};
        putReg(ix, v, gap);
      end
      checkAll(mLock ? "R3 random" : "R2 random");
    end
    putReg(8'hFF, 8'hFF, 0); checkAll("R3 final commit");
    chk("R8 clean so far", 32'(errFlag), 0);

    // R8 framing errors
    sendByte(8'h55, 0);
    chk("R8 bad prefix", 32'(errFlag), 1);
    sendByte(8'h20, 0); sendByte(8'h1F, 0); sendByte(8'h01, 0);
    checkAll("R8 discard");
    putReg(8'h1F, 8'h05, 0);
    checkAll("R8 resync");
    sendByte(8'hAF, 0); sendByte(8'h33, 0);
    sendByte(8'h1F, 0); sendByte(8'h01, 0);
    checkAll("R8 bad opcode discard");
    chk("R8 sticky", 32'(errFlag), 1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule